// File: doc/BRIEF.md
# Priority Packet Output Arbiter

This block merges fixed-size 60-bit packets from four internal producers onto one serial output line. The producers are low-latency regional readout, packets relayed from the previous chip on a daisy chain, full level-1 readout, and status reports. Each producer writes whole packets into its own small queue. A fixed priority picker chooses the next queue to serve. A shift register then sends the chosen packet one bit per clock, most significant bit first.

A packet that has started is always sent to its end before any other packet. When the last bit of a packet leaves and another packet is waiting, the next one starts on the very next clock, so a busy link has no gap. When nothing is waiting, the line holds a constant idle level. Producers set the top bit of every packet header to the opposite level, so a packet start can never be confused with idle. Each queue reports when it is full, which tells its producer to hold off.

Top module: `pkt_link_arb`

## Requirements
- R1: After reset, `ser_o` is 0 (the idle level), `frame_o` is 0, and every bit of `full_o` is 0.
- R2: A packet occupies exactly 60 consecutive clocks with `frame_o` high. Its bits appear on `ser_o` from bit 59 down to bit 0.
- R3: When a packet is pushed into an empty block with an idle link, `frame_o` is still 0 after the push edge and goes to 1 after the following edge, which carries bit 59.
- R4: Sources are indexed 0 = regional, 1 = daisy chain, 2 = level-1, 3 = status. When several queues hold packets at a packet boundary, the lowest index is served first.
- R5: A packet in progress is never interrupted, even when a higher priority packet arrives.
- R6: If any queue holds a packet when the last bit of the current packet leaves, the next packet begins on the next clock, and `frame_o` stays high.
- R7: Each queue holds 4 packets, and `full_o[i]` is 1 while queue i holds 4. A push into a full queue is dropped: that packet is never sent.
- R8: While no packet is being sent, `ser_o` is 0 and `frame_o` is 0. Valid packets carry 1 in bit 59.
- R9: Packets from the same source leave in the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 4 | Per-source write strobe, index = source |
| pkt_i | input | 240 | Per-source packet, source i in bits [60*i+59 : 60*i] |
| full_o | output | 4 | Per-source queue full, backpressure to producers |
| ser_o | output | 1 | Serial line data |
| frame_o | output | 1 | High while a packet bit is on the line |

## Verification
A single packet on an idle link checks the start latency, the bit order and the idle level that follows. All four sources are loaded together while a status packet is being sent. This tells apart fixed priority from arrival order, and shows that the packet in progress finishes first. A burst of six regional pushes on consecutive clocks fills one queue. It shows the full flag, the dropped sixth packet, order within a source, and gap-free back-to-back sending. A reference model in the bench compares every output on every clock.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;
    localparam int NUM_SRC  = 4;
    localparam int PKT_BITS = 60;
    localparam int Q_DEPTH  = 4;

    // Source index order is also the service priority (lowest index first).
    typedef enum int {
        SRC_REGION = 0,
        SRC_CHAIN  = 1,
        SRC_LVL1   = 2,
        SRC_STATUS = 3
    } src_e;
endpackage

// File: rtl/pkt_src_fifo.sv
module pkt_src_fifo #(
    parameter int W     = 60,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t st_q, st_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign dout  = st_q.mem[st_q.rd];

    always_comb begin
        logic do_push, do_pop;
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pkt_prio_pick.sv
module pkt_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/pkt_shifter.sv
module pkt_shifter #(
    parameter int   W        = 60,
    parameter logic IDLE_BIT = 1'b0,
    localparam int  CW       = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  din,
    output logic          ser,
    output logic          busy,
    output logic          last,
    output logic [CW-1:0] bit_cnt
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          busy;
    } st_t;

    st_t st_q, st_d;

    assign ser     = st_q.busy ? st_q.sh[W-1] : IDLE_BIT;
    assign busy    = st_q.busy;
    assign last    = st_q.busy && (st_q.cnt == '0);
    assign bit_cnt = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = din;
            st_d.cnt  = CW'(W - 1);
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            st_d.sh = {st_q.sh[W-2:0], IDLE_BIT};
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pkt_link_arb.sv
module pkt_link_arb
    import pkt_link_pkg::*;
#(
    parameter int   NSRC     = NUM_SRC,
    parameter int   PKT_W    = PKT_BITS,
    parameter int   DEPTH    = Q_DEPTH,
    parameter logic IDLE_BIT = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             push_i,
    input  logic [NSRC-1:0][PKT_W-1:0]  pkt_i,
    output logic [NSRC-1:0]             full_o,
    output logic                        ser_o,
    output logic                        frame_o
);
    localparam int CW = $clog2(PKT_W);

    logic [NSRC-1:0][PKT_W-1:0] fifo_dout;
    logic [NSRC-1:0]            fifo_empty;
    logic [NSRC-1:0]            grant;
    logic [NSRC-1:0]            pop;
    logic                       any_wait;
    logic                       sh_busy, sh_last, load;
    logic [CW-1:0]              bit_cnt;
    logic [PKT_W-1:0]           load_word;

    for (genvar g = 0; g < NSRC; g++) begin : g_q
        pkt_src_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_i[g]),
            .din   (pkt_i[g]),
            .pop   (pop[g]),
            .dout  (fifo_dout[g]),
            .empty (fifo_empty[g]),
            .full  (full_o[g])
        );
    end

    pkt_prio_pick #(.N(NSRC)) u_pick (
        .req   (~fifo_empty),
        .grant (grant),
        .any   (any_wait)
    );

    // A new packet may start when the line is free or on the last bit.
    assign load = any_wait && (!sh_busy || sh_last);
    assign pop  = load ? grant : '0;

    always_comb begin
        load_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) load_word = load_word | fifo_dout[i];
        end
    end

    pkt_shifter #(.W(PKT_W), .IDLE_BIT(IDLE_BIT)) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .din     (load_word),
        .ser     (ser_o),
        .busy    (sh_busy),
        .last    (sh_last),
        .bit_cnt (bit_cnt)
    );

    assign frame_o = sh_busy;
endmodule

// File: rtl/pkt_link_arb_chk.sv
module pkt_link_arb_chk #(
    parameter int  NSRC  = 4,
    parameter int  PKT_W = 60,
    localparam int CW    = $clog2(PKT_W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] push_i,
    input logic [NSRC-1:0] full_o,
    input logic            frame_o,
    input logic [CW-1:0]   bit_cnt,
    input logic [NSRC-1:0] fifo_empty,
    input logic [NSRC-1:0] grant
);
    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o && bit_cnt == '0 |=> !frame_o || bit_cnt == CW'(PKT_W - 1));

    // R5
    no_interrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o && bit_cnt != '0 |=> frame_o && bit_cnt == CW'($past(bit_cnt) - 1'b1));

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o && bit_cnt == '0 && fifo_empty != '1 |=> frame_o);

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & fifo_empty) == '0));

    for (genvar g = 0; g < NSRC; g++) begin : g_full
        // R7
        full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(full_o[g]) |-> $past(push_i[g]));
    end
endmodule

bind pkt_link_arb pkt_link_arb_chk #(.NSRC(NSRC), .PKT_W(PKT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .full_o     (full_o),
    .frame_o    (frame_o),
    .bit_cnt    (bit_cnt),
    .fifo_empty (fifo_empty),
    .grant      (grant)
);

// File: tb/pkt_link_arb_tb.sv
module pkt_link_arb_tb;
    typedef logic [59:0] w_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     push_i = '0;
    logic [3:0][59:0] pkt_i = '0;
    logic [3:0]     full_o;
    logic           ser_o, frame_o;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    pkt_link_arb u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pkt_i(pkt_i),
        .full_o(full_o), .ser_o(ser_o), .frame_o(frame_o)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    w_t  mq [4][$];
    w_t  m_sh;
    int  m_cnt = 0;
    bit  m_busy = 1'b0;
    bit  acc [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) mq[i].delete();
            m_busy = 1'b0; m_cnt = 0; m_sh = '0;
        end else begin
            int win;
            for (int i = 0; i < 4; i++) acc[i] = push_i[i] && (mq[i].size() < 4);
            win = -1;
            if (!m_busy || m_cnt == 0)
                for (int i = 0; i < 4; i++)
                    if (win < 0 && mq[i].size() > 0) win = i;
            if (win >= 0) begin
                m_sh = mq[win].pop_front(); m_cnt = 59; m_busy = 1'b1;
            end else if (m_busy) begin
                m_sh = m_sh << 1;
                if (m_cnt == 0) m_busy = 1'b0; else m_cnt--;
            end
            for (int i = 0; i < 4; i++) if (acc[i]) mq[i].push_back(pkt_i[i]);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] ef;
            for (int i = 0; i < 4; i++) ef[i] = (mq[i].size() == 4);
            check({cur_req, " frame"}, 64'(frame_o), 64'(m_busy));
            check({cur_req, " ser"},   64'(ser_o),   64'(m_busy ? m_sh[59] : 1'b0));
            check({cur_req, " full"},  64'(full_o),  64'(ef));
        end
    end

    // ---------------- receiver ----------------
    w_t rx[$];
    w_t rx_acc;
    int rx_n = 0, run = 0, last_run = 0;

    always @(negedge clk) begin
        if (rst_n && frame_o) begin
            rx_acc = {rx_acc[58:0], ser_o};
            rx_n++;
            run++;
            if (rx_n == 60) begin rx.push_back(rx_acc); rx_n = 0; end
        end else begin
            if (run != 0) last_run = run;
            run = 0;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic w_t mk(input int src, input int seq);
        return {1'b1, 2'(src), 8'(seq), 49'h1_5A5A_C3C3_0F0F ^ 49'(seq * 977 + src)};
    endfunction

    task automatic step(input logic [3:0] mask, input w_t d0, input w_t d1,
                        input w_t d2, input w_t d3);
        push_i = mask;
        pkt_i[0] = d0; pkt_i[1] = d1; pkt_i[2] = d2; pkt_i[3] = d3;
        @(posedge clk);
        @(negedge clk);
        push_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ser", 64'(ser_o), 64'd0);
        check("R1 frame", 64'(frame_o), 64'd0);
        check("R1 full", 64'(full_o), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R3 / R2 / R8: single packet on idle link
        cur_req = "R3";
        step(4'b0001, mk(0, 1), '0, '0, '0);
        check("R3 frame after push edge", 64'(frame_o), 64'd0);
        @(negedge clk);
        check("R3 frame after next edge", 64'(frame_o), 64'd1);
        check("R3 first bit", 64'(ser_o), 64'd1);
        cur_req = "R2";
        idle(70);
        check("R2 frame length", 64'(last_run), 64'd60);
        check("R2 word MSB first", 64'(rx[0]), 64'(mk(0, 1)));
        cur_req = "R8";
        check("R8 idle ser", 64'(ser_o), 64'd0);
        check("R8 idle frame", 64'(frame_o), 64'd0);
        rx.delete();

        // R4 / R5: all sources waiting while a status packet is on the line
        cur_req = "R4";
        step(4'b1000, '0, '0, '0, mk(3, 10));
        idle(3);
        step(4'b1111, mk(0, 11), mk(1, 12), mk(2, 13), mk(3, 14));
        idle(320);
        check("R5 rx count", 64'(rx.size()), 64'd5);
        if (rx.size() == 5) begin
            check("R5 current packet finished first", 64'(rx[0]), 64'(mk(3, 10)));
            check("R4 regional first", 64'(rx[1]), 64'(mk(0, 11)));
            check("R4 chain second", 64'(rx[2]), 64'(mk(1, 12)));
            check("R4 level-1 third", 64'(rx[3]), 64'(mk(2, 13)));
            check("R4 status last", 64'(rx[4]), 64'(mk(3, 14)));
        end
        check("R6 gap-free run", 64'(last_run), 64'd300);
        rx.delete();

        // R7 / R9 / R6: burst into one queue
        cur_req = "R7";
        for (int k = 0; k < 5; k++) step(4'b0001, mk(0, 20 + k), '0, '0, '0);
        check("R7 full after 4 held", 64'(full_o[0]), 64'd1);
        step(4'b0001, mk(0, 25), '0, '0, '0);
        check("R7 still full after dropped push", 64'(full_o[0]), 64'd1);
        idle(320);
        check("R7 dropped packet absent", 64'(rx.size()), 64'd5);
        cur_req = "R9";
        for (int k = 0; k < 5; k++)
            if (k < rx.size()) check("R9 order in source", 64'(rx[k]), 64'(mk(0, 20 + k)));
        check("R6 back-to-back run", 64'(last_run), 64'd300);
        check("R7 full cleared", 64'(full_o), 64'd0);
        check("R8 idle after drain", 64'(ser_o), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule